// File: doc/BRIEF.md
# Computation Sharing Integer Multiplier

This block multiplies an unsigned W-bit operand X by an unsigned W-bit coefficient C and returns the full 2W-bit product. It has no general partial-product array. A small front stage forms six multiples of X once: X, 2X, 3X, 4X, 8X and 12X. Only two of them need an adder (3X and 12X). The others are plain wiring shifts. The number of multiples stays at six whatever the width.

The coefficient is split into two-bit groups, counted from the least significant bit. Each group drives its own four-way selector. Within each four-bit nibble, the lower group chooses zero, X, 2X or 3X, and the upper group chooses zero, 4X, 8X or 12X. The two choices are added to give X times that nibble. Each nibble term is then weighted by its position and all terms are summed.

Every selector is steered directly by coefficient bits, so all groups work in parallel. The sum is captured in one output register, which gives one cycle of latency. The width W is a parameter and must be a multiple of four; any other value stops elaboration.

Top module: `csm_mult`

## Requirements
- R1: While `rst` is high at a rising clock edge, `prod` becomes 0 at that edge and stays 0, whatever the operands are.
- R2: After reset, `prod` equals op_x*op_c exactly, as a 2W-bit unsigned value, for the operands sampled at the previous rising edge. This holds for every operand pair.
- R3: If either operand is zero, the registered product is zero.
- R4: All-ones operands give (2^W-1)^2, which is 65025 for W=8.
- R5: Coefficient bits [4n+3:4n] form nibble n. The product of X with nibble n is weighted by 2^(4n). A nibble that is zero contributes nothing to the product.
- R6: Within each nibble, bits [1:0] select 0, X, 2X or 3X for codes 0 to 3. Bits [3:2] select 0, 4X, 8X or 12X for codes 0 to 3.
- R7: The coefficient 0110_0011 (99) selects 3X, 0, 2X and 4X from the lowest group upward. The result is 99X.
- R8: With W=16, the block meets R2 to R6 over its 32-bit product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_x | input | W | Unsigned operand X |
| op_c | input | W | Unsigned coefficient C |
| prod | output | 2W | Registered product X*C |

## Verification
At W=8 the bench sweeps all 65536 operand pairs against a reference product computed in the bench. This catches any wrong multiple, selector code or weight.

Coefficients with a single nonzero nibble, holding the values 1, 2, 3, 4, 8 and 12, are tried at each nibble position. These separate a fault in the low-group selector from one in the high-group selector, and both from an error in the nibble weighting. Zero operands, all-ones operands and the value 99 cover the edges and the two-addition path.

A second instance at W=16 is driven with zeros, all-ones, one-hot coefficients and pseudo-random pairs. This shows that the generated structure scales to four nibbles.

// File: rtl/csm_pkg.sv
package csm_pkg;

    // Positions of the shared multiples inside the pre-computed vector
    localparam int MUL_1  = 0;
    localparam int MUL_2  = 1;
    localparam int MUL_3  = 2;
    localparam int MUL_4  = 3;
    localparam int MUL_8  = 4;
    localparam int MUL_12 = 5;
    localparam int NUM_MULTS = 6;

    localparam int GROUP_BITS  = 2;
    localparam int NIBBLE_BITS = 4;

    // Code carried by one two-bit coefficient group
    typedef enum logic [1:0] {
        GC_ZERO  = 2'd0,
        GC_ONE   = 2'd1,
        GC_TWO   = 2'd2,
        GC_THREE = 2'd3
    } group_code_e;

    // Bit offset at which nibble n lands in the product
    function automatic int nib_offset(input int n);
        return n * NIBBLE_BITS;
    endfunction

endpackage

// File: rtl/csm_precompute.sv
module csm_precompute #(
    parameter int W  = 8,
    parameter int MW = W + 4
) (
    input  logic [W-1:0]                        op_x,
    output logic [csm_pkg::NUM_MULTS-1:0][MW-1:0] mults
);
    import csm_pkg::*;

    logic [MW-1:0] x_1, x_2, x_3, x_4, x_8, x_12;

    always_comb begin
        x_1  = MW'(op_x);
        x_2  = x_1 << 1;
        x_3  = x_1 + x_2;      // first addition
        x_4  = x_1 << 2;
        x_8  = x_1 << 3;
        x_12 = x_4 + x_8;      // second addition
    end

    always_comb begin
        mults         = '0;
        mults[MUL_1]  = x_1;
        mults[MUL_2]  = x_2;
        mults[MUL_3]  = x_3;
        mults[MUL_4]  = x_4;
        mults[MUL_8]  = x_8;
        mults[MUL_12] = x_12;
    end

    // R6: the upper-set entry 12X must be four times the lower-set entry 3X
    always_comb begin
        p_twelve_is_four_threes_r6: assert (x_12 == (x_3 << 2));
    end

endmodule

// File: rtl/csm_group_sel.sv
module csm_group_sel #(
    parameter int MW    = 12,
    parameter bit UPPER = 1'b0
) (
    input  logic [1:0]                            code,
    input  logic [csm_pkg::NUM_MULTS-1:0][MW-1:0] mults,
    output logic [MW-1:0]                         term
);
    import csm_pkg::*;

    localparam int IDX_A = UPPER ? MUL_4  : MUL_1;
    localparam int IDX_B = UPPER ? MUL_8  : MUL_2;
    localparam int IDX_C = UPPER ? MUL_12 : MUL_3;

    group_code_e gc;

    always_comb begin
        gc = group_code_e'(code);
        unique case (gc)
            GC_ZERO:  term = '0;
            GC_ONE:   term = mults[IDX_A];
            GC_TWO:   term = mults[IDX_B];
            GC_THREE: term = mults[IDX_C];
            default:  term = '0;
        endcase
    end

    // R5: a zero group adds no term; the other codes pick an entry of the right size
    always_comb begin
        if (code == 2'd0) begin
            p_zero_group_r5: assert (term == '0);
        end
        if (code == 2'd2) begin
            p_double_entry_r6: assert (term == (mults[IDX_A] << 1));
        end
    end

endmodule

// File: rtl/csm_mult.sv
module csm_mult #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   op_x,
    input  logic [W-1:0]   op_c,
    output logic [2*W-1:0] prod
);
    import csm_pkg::*;

    localparam int NNIB = W / NIBBLE_BITS;
    localparam int MW   = W + 4;
    localparam int PW   = 2 * W;

    if ((W % NIBBLE_BITS) != 0 || W < NIBBLE_BITS) begin : g_bad_width
        $error("csm_mult: W must be a positive multiple of 4");
    end

    logic [NUM_MULTS-1:0][MW-1:0] mults;
    logic [NNIB-1:0][MW-1:0]      lo_term;
    logic [NNIB-1:0][MW-1:0]      hi_term;
    logic [NNIB-1:0][MW-1:0]      nib_sum;
    logic [PW-1:0]                acc;

    csm_precompute #(.W(W), .MW(MW)) u_pre (
        .op_x  (op_x),
        .mults (mults)
    );

    for (genvar n = 0; n < NNIB; n++) begin : g_nib
        csm_group_sel #(.MW(MW), .UPPER(1'b0)) u_lo (
            .code  (op_c[NIBBLE_BITS*n +: GROUP_BITS]),
            .mults (mults),
            .term  (lo_term[n])
        );
        csm_group_sel #(.MW(MW), .UPPER(1'b1)) u_hi (
            .code  (op_c[NIBBLE_BITS*n+GROUP_BITS +: GROUP_BITS]),
            .mults (mults),
            .term  (hi_term[n])
        );

        assign nib_sum[n] = lo_term[n] + hi_term[n];

        // R5: each nibble sum equals X times that coefficient nibble
        always_comb begin
            p_nibble_sum_r5: assert (nib_sum[n] ==
                MW'(op_x) * MW'(op_c[NIBBLE_BITS*n +: NIBBLE_BITS]));
        end
    end

    always_comb begin
        acc = '0;
        for (int n = 0; n < NNIB; n++) begin
            acc = acc + (PW'(nib_sum[n]) << nib_offset(n));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prod <= '0;
        else     prod <= acc;
    end

    // R2: the registered result is the exact product of last cycle's operands
    p_exact_product_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> prod == PW'($past(op_x)) * PW'($past(op_c)));

    // R3: a zero operand forces a zero result
    p_zero_operand_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(op_x) == '0 || $past(op_c) == '0)) |-> prod == '0);

    // R5: unit coefficient passes X through unchanged
    p_unit_coef_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_c) == W'(1)) |-> prod == PW'($past(op_x)));

endmodule

// File: tb/csm_mult_bench.sv
module csm_mult_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  x8  = '0;
    logic [7:0]  c8  = '0;
    logic [15:0] p8;
    logic [15:0] x16 = '0;
    logic [15:0] c16 = '0;
    logic [31:0] p16;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 1'b0;
    logic [31:0] seed = 32'h1d872b41;

    always #2 clk = ~clk;   // 4 ns period

    csm_mult #(.W(8)) u_csm_mult (
        .clk(clk), .rst(rst), .op_x(x8), .op_c(c8), .prod(p8)
    );

    csm_mult #(.W(16)) u_csm_mult_w16 (
        .clk(clk), .rst(rst), .op_x(x16), .op_c(c16), .prod(p16)
    );

    task automatic check8(input string req, input logic [15:0] exp);
        total++;
        if (p8 !== exp) begin
            bad++;
            $display("FAIL %s W=8: got %0d expected %0d", req, p8, exp);
        end
    endtask

    task automatic check16(input string req, input logic [31:0] exp);
        total++;
        if (p16 !== exp) begin
            bad++;
            $display("FAIL %s W=16: got %0d expected %0d", req, p16, exp);
        end
    endtask

    // drive at a falling edge, the result is registered at the next rising edge,
    // and the check happens at the falling edge after that
    task automatic apply8(input string req, input logic [7:0] x, input logic [7:0] c);
        @(negedge clk);
        x8 = x; c8 = c;
        @(negedge clk);
        check8(req, 16'(x) * 16'(c));
    endtask

    task automatic apply16(input string req, input logic [15:0] x, input logic [15:0] c);
        @(negedge clk);
        x16 = x; c16 = c;
        @(negedge clk);
        check16(req, 32'(x) * 32'(c));
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] v;
        v = s ^ (s << 13);
        v = v ^ (v >> 17);
        v = v ^ (v << 5);
        return v;
    endfunction

    task automatic t_reset_r1();
        @(negedge clk);
        rst = 1'b1; x8 = 8'hff; c8 = 8'hff; x16 = 16'hffff; c16 = 16'hffff;
        @(negedge clk);
        check8("R1", 16'd0);
        check16("R1", 32'd0);
        @(negedge clk);
        check8("R1", 16'd0);
        rst = 1'b0;
        @(negedge clk);
        check8("R2", 16'd65025);
    endtask

    task automatic t_zero_r3();
        apply8("R3", 8'd0, 8'd173);
        apply8("R3", 8'd201, 8'd0);
        apply8("R3", 8'd0, 8'd0);
        apply16("R3", 16'd0, 16'hbeef);
        apply16("R3", 16'hcafe, 16'd0);
    endtask

    task automatic t_all_ones_r4();
        apply8("R4", 8'hff, 8'hff);
        apply16("R4", 16'hffff, 16'hffff);
    endtask

    task automatic t_nibbles_r5_r6();
        int vals[6] = '{1, 2, 3, 4, 8, 12};
        for (int n = 0; n < 2; n++) begin
            foreach (vals[k]) begin
                apply8("R5/R6", 8'hb7, 8'(vals[k] << (4 * n)));
            end
        end
        for (int n = 0; n < 4; n++) begin
            foreach (vals[k]) begin
                apply16("R8/R6", 16'hd39b, 16'(vals[k] << (4 * n)));
            end
        end
    endtask

    task automatic t_worked_r7();
        apply8("R7", 8'b0010_0011, 8'b0110_0011);
        apply8("R7", 8'd255, 8'd99);
    endtask

    task automatic t_exhaustive_r2();
        logic [15:0] exp_prev;
        bit          have_prev;
        have_prev = 1'b0;
        exp_prev  = '0;
        for (int xi = 0; xi < 256; xi++) begin
            for (int ci = 0; ci < 256; ci++) begin
                @(negedge clk);
                if (have_prev) check8("R2", exp_prev);
                x8 = 8'(xi); c8 = 8'(ci);
                exp_prev  = 16'(xi) * 16'(ci);
                have_prev = 1'b1;
            end
        end
        @(negedge clk);
        check8("R2", exp_prev);
    endtask

    task automatic t_random_r8();
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            logic [15:0] b;
            seed = next_rand(seed);
            a = seed[15:0];
            b = seed[31:16];
            apply16("R8", a, b);
        end
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        t_reset_r1();
        t_zero_r3();
        t_all_ones_r4();
        t_nibbles_r5_r6();
        t_worked_r7();
        t_exhaustive_r2();
        t_random_r8();
        done = 1'b1;
    end

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        while (!done && cycles < 190000) @(negedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule